// File: doc/BRIEF.md
# Byte-Wide GPIO Port with Per-Line Interrupt Detection

This block is an eight-line general-purpose I/O port with a small register bus. Each line can be set to input or output with a direction bit. Output lines drive the value held in the data register. Reading the data register returns the synchronized pin level for input lines and the stored drive value for output lines.

Every line also feeds an interrupt detector. A line is either level-sensitive or edge-sensitive, and its polarity bit picks high/rising or low/falling. Edge events are held in sticky pending bits until software clears them through a write-one-to-clear register. Level events follow the pin and are never latched. An enable mask gates each line onto its own interrupt output and onto one combined request. An optional debounce stage per line makes the input hold steady for a number of ticks of a slow strobe before the detector sees the change. Software can emulate both-edge detection by flipping a line's polarity after each event.

Register offsets, which software depends on:

| Offset | Register |
|--------|----------|
| 0x00 | data |
| 0x10 | direction |
| 0x90 | edge-mode select |
| 0x94 | polarity select |
| 0x98 | event clear |
| 0x9C | interrupt enable |
| 0xA0 | masked status (read-only) |
| 0xA4 | raw status (read-only) |
| 0xA8 | debounce enable |

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, every writable register is 0, so `pin_oe`, `pin_out`, `line_irq` and `irq` are all 0.
- R2: Direction register (0x10): bit 1 makes the line an output. `pin_oe` equals the direction register and `pin_out` equals the data register (0x00), starting one cycle after the write. Both registers read back what was written.
- R3: A read of 0x00 returns, per bit, the stored data value when the direction bit is 1. When the direction bit is 0 it returns the pin level after a two-flop synchronizer.
- R4: Edge-mode bit 0 (0x90) selects level mode. In level mode a line is pending while its filtered input equals its polarity bit (0x94: 1 = high, 0 = low). The pending bit clears as soon as the input leaves that level.
- R5: Edge-mode bit 1 selects edge mode. With polarity 1 a rising edge sets a sticky pending bit; with polarity 0 a falling edge sets it. The opposite edge has no effect.
- R6: Writing 0x98 clears the edge pending bit of each line written as 1 and leaves lines written as 0 unchanged. If a new edge arrives in the same cycle, the new edge wins.
- R7: `line_irq` is the pending bits ANDed with the enable register (0x9C). `irq` is the OR of `line_irq`. Clearing an enable bit removes that line's output one cycle after the write.
- R8: A read of 0xA0 returns the pending bits ANDed with enable. A read of 0xA4 returns the pending bits without the enable mask.
- R9: When a line's debounce bit (0xA8) is 1, the detector sees a new input level only on the fourth `db_tick` pulse during which the synchronized input differs from the filtered value.
- R10: With debounce on, a level change that reverts before the fourth tick produces no event. The run of ticks counted toward a change starts again from zero.
- R11: Clearing a line's edge-mode bit discards its latched edge event.
- R12: Writes to 0xA0, 0xA4 or an unmapped offset change no register. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| pin_in | input | 8 | Pin levels, asynchronous |
| pin_out | output | 8 | Driven value for output lines |
| pin_oe | output | 8 | Output enable per line |
| db_tick | input | 1 | Slow strobe that paces debounce |
| line_irq | output | 8 | Enabled pending bit per line |
| irq | output | 1 | OR of all `line_irq` bits |

## Verification
Each result has its own delay after a stimulus:

- **Register writes:** show on `pin_oe`, `pin_out` and the readback one clock after the write.
- **Pin changes, data read and level mode:** need two edges through the synchronizer before they reach the data read and level pending.
- **Edge mode:** an edge event latches one edge after that.
- **Debounce:** the filtered value flips at the clock edge that samples the fourth qualifying tick. The event follows one edge later.

The bench drives inputs and samples outputs on falling clock edges. After every pin change or tick it waits at least four clocks before it reads anything. The checks for "not yet" states (three ticks, a short glitch) are taken while the input is still held, before the next qualifying tick.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int PORT_W = 8;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] ADR_DATA = 8'h00;
    localparam logic [ADDR_W-1:0] ADR_DIR  = 8'h10;
    localparam logic [ADDR_W-1:0] ADR_MODE = 8'h90;
    localparam logic [ADDR_W-1:0] ADR_POL  = 8'h94;
    localparam logic [ADDR_W-1:0] ADR_CLR  = 8'h98;
    localparam logic [ADDR_W-1:0] ADR_EN   = 8'h9C;
    localparam logic [ADDR_W-1:0] ADR_STAT = 8'hA0;
    localparam logic [ADDR_W-1:0] ADR_RAW  = 8'hA4;
    localparam logic [ADDR_W-1:0] ADR_DBEN = 8'hA8;

    typedef struct packed {
        logic [PORT_W-1:0] data;
        logic [PORT_W-1:0] dir;
        logic [PORT_W-1:0] edge_mode;
        logic [PORT_W-1:0] pol_hi;
        logic [PORT_W-1:0] en;
        logic [PORT_W-1:0] dben;
    } cfg_t;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/gpio_irq_debounce.sv
module gpio_irq_debounce #(
    parameter int TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic din,
    output logic dout
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    typedef struct packed {
        logic          val;
        logic [CW-1:0] cnt;
    } db_t;

    db_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (din == st_q.val) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (st_q.cnt == LAST) begin
                st_d.val = din;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.val;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] edge_mode,
    input  logic [W-1:0] pol_hi,
    input  logic [W-1:0] clr,
    output logic [W-1:0] evt_set,
    output logic [W-1:0] evt_q,
    output logic [W-1:0] pend
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] evt;
    } det_t;

    det_t st_d, st_q;
    logic [W-1:0] rise, fall;

    always_comb begin
        rise      = lvl & ~st_q.prev;
        fall      = ~lvl & st_q.prev;
        evt_set   = edge_mode & ((pol_hi & rise) | (~pol_hi & fall));
        st_d      = st_q;
        st_d.prev = lvl;
        st_d.evt  = edge_mode & ((st_q.evt & ~clr) | evt_set);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign evt_q = st_q.evt;
    assign pend  = (edge_mode & st_q.evt) | (~edge_mode & ~(lvl ^ pol_hi));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int DB_TICKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe,
    input  logic              db_tick,
    output logic [PORT_W-1:0] line_irq,
    output logic              irq
);
    cfg_t cfg_d, cfg_q;

    logic [PORT_W-1:0] pin_s;
    logic [PORT_W-1:0] db_q;
    logic [PORT_W-1:0] filt;
    logic [PORT_W-1:0] clr_mask;
    logic [PORT_W-1:0] evt_set;
    logic [PORT_W-1:0] evt_q;
    logic [PORT_W-1:0] pend_raw;

    always_comb begin
        cfg_d = cfg_q;
        if (bus_wr) begin
            case (bus_addr)
                ADR_DATA: cfg_d.data      = bus_wdata;
                ADR_DIR:  cfg_d.dir       = bus_wdata;
                ADR_MODE: cfg_d.edge_mode = bus_wdata;
                ADR_POL:  cfg_d.pol_hi    = bus_wdata;
                ADR_EN:   cfg_d.en        = bus_wdata;
                ADR_DBEN: cfg_d.dben      = bus_wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign clr_mask = (bus_wr && bus_addr == ADR_CLR) ? bus_wdata : '0;

    gpio_irq_sync #(.W(PORT_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_s)
    );

    for (genvar g = 0; g < PORT_W; g++) begin : g_db
        gpio_irq_debounce #(.TICKS(DB_TICKS)) u_db (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (db_tick),
            .din   (pin_s[g]),
            .dout  (db_q[g])
        );
    end

    assign filt = (cfg_q.dben & db_q) | (~cfg_q.dben & pin_s);

    gpio_irq_detect #(.W(PORT_W)) u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl       (filt),
        .edge_mode (cfg_q.edge_mode),
        .pol_hi    (cfg_q.pol_hi),
        .clr       (clr_mask),
        .evt_set   (evt_set),
        .evt_q     (evt_q),
        .pend      (pend_raw)
    );

    assign line_irq = pend_raw & cfg_q.en;
    assign irq      = |line_irq;
    assign pin_out  = cfg_q.data;
    assign pin_oe   = cfg_q.dir;

    always_comb begin
        case (bus_addr)
            ADR_DATA: bus_rdata = (cfg_q.dir & cfg_q.data) | (~cfg_q.dir & pin_s);
            ADR_DIR:  bus_rdata = cfg_q.dir;
            ADR_MODE: bus_rdata = cfg_q.edge_mode;
            ADR_POL:  bus_rdata = cfg_q.pol_hi;
            ADR_EN:   bus_rdata = cfg_q.en;
            ADR_STAT: bus_rdata = pend_raw & cfg_q.en;
            ADR_RAW:  bus_rdata = pend_raw;
            ADR_DBEN: bus_rdata = cfg_q.dben;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
    import gpio_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [PORT_W-1:0] bus_wdata,
    input logic [PORT_W-1:0] pin_out,
    input logic [PORT_W-1:0] pin_oe,
    input logic [PORT_W-1:0] line_irq,
    input logic              db_tick,
    input logic [PORT_W-1:0] db_q,
    input logic [PORT_W-1:0] evt_q,
    input logic [PORT_W-1:0] evt_set
);
    p_oe_tracks_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADR_DIR) |=> (pin_oe == $past(bus_wdata)));

    p_out_tracks_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADR_DATA) |=> (pin_out == $past(bus_wdata)));

    p_clear_takes_effect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADR_CLR)
        |=> ((evt_q & $past(bus_wdata) & ~$past(evt_set)) == '0));

    p_disable_silences_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADR_EN && bus_wdata == '0) |=> (line_irq == '0));

    p_filter_moves_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !db_tick |=> $stable(db_q));
endmodule

bind gpio_irq_port gpio_irq_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .line_irq  (line_irq),
    .db_tick   (db_tick),
    .db_q      (db_q),
    .evt_q     (evt_q),
    .evt_set   (evt_set)
);

// File: tb/tb_gpio_irq_port.sv
module tb_gpio_irq_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out, pin_oe, line_irq;
    logic       db_tick = 1'b0;
    logic       irq;

    int errors = 0;
    int checks = 0;
    logic [7:0] rv;

    always #10 clk = ~clk;

    gpio_irq_port dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .db_tick(db_tick),
        .line_irq(line_irq), .irq(irq)
    );

    function automatic logic [7:0] exp_data(logic [7:0] dir, logic [7:0] dat, logic [7:0] pins);
        return (dir & dat) | (~dir & pins);
    endfunction

    function automatic logic [7:0] exp_level(logic [7:0] pins, logic [7:0] pol);
        return ~(pins ^ pol);
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #2 d = bus_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        db_tick = 1'b1;
        @(negedge clk);
        db_tick = 1'b0;
        idle(2);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(20 * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] dir, dat, pins, pol, en;
        void'($urandom(32'd1234));
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk("R1 pin_oe", pin_oe, 8'h00);
        chk("R1 pin_out", pin_out, 8'h00);
        chk("R1 line_irq", line_irq, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        rd(8'h9C, rv); chk("R1 enable", rv, 8'h00);

        // R2 R3 random direction/data/pins
        for (int i = 0; i < 40; i++) begin
            dir = 8'($urandom); dat = 8'($urandom); pins = 8'($urandom);
            if (i == 0) begin dir = 8'hFF; pins = 8'h00; end
            if (i == 1) begin dir = 8'h00; pins = 8'hA5; end
            wr(8'h10, dir);
            wr(8'h00, dat);
            pin_in = pins;
            idle(3);
            chk("R2 pin_oe", pin_oe, dir);
            chk("R2 pin_out", pin_out, dat);
            rd(8'h10, rv); chk("R2 dir readback", rv, dir);
            rd(8'h00, rv); chk("R3 data read", rv, exp_data(dir, dat, pins));
        end

        // R4 R7 R8 random level-mode patterns
        wr(8'h90, 8'h00);
        for (int i = 0; i < 30; i++) begin
            pol = 8'($urandom); en = 8'($urandom); pins = 8'($urandom);
            wr(8'h94, pol);
            wr(8'h9C, en);
            pin_in = pins;
            idle(4);
            rd(8'hA4, rv); chk("R4 R8 raw level", rv, exp_level(pins, pol));
            rd(8'hA0, rv); chk("R8 masked", rv, exp_level(pins, pol) & en);
            chk("R7 line_irq", line_irq, exp_level(pins, pol) & en);
            chk("R7 irq", {7'd0, irq}, {7'd0, |(exp_level(pins, pol) & en)});
        end
        // R4 level not latched
        wr(8'h94, 8'hFF); pin_in = 8'h0F; idle(4);
        rd(8'hA4, rv); chk("R4 level set", rv, 8'h0F);
        pin_in = 8'h00; idle(4);
        rd(8'hA4, rv); chk("R4 level released", rv, 8'h00);

        // R5 edge mode: lines 0-3 rising, 4-7 falling
        wr(8'h9C, 8'h00);
        wr(8'h94, 8'h0F);
        wr(8'h90, 8'hFF);
        idle(2);
        rd(8'hA4, rv); chk("R5 no event yet", rv, 8'h00);
        pin_in = 8'hFF; idle(4);
        rd(8'hA4, rv); chk("R5 rising only", rv, 8'h0F);
        pin_in = 8'h00; idle(4);
        rd(8'hA4, rv); chk("R5 falling sticky", rv, 8'hFF);

        // R6 event clear
        wr(8'h98, 8'h05); idle(1);
        rd(8'hA4, rv); chk("R6 clear mask", rv, 8'hFA);
        wr(8'h98, 8'h00); idle(1);
        rd(8'hA4, rv); chk("R6 zero clear", rv, 8'hFA);

        // R7 R8 enable gating on latched events
        wr(8'h9C, 8'h30); idle(1);
        rd(8'hA0, rv); chk("R8 masked edge", rv, 8'h30);
        chk("R7 line_irq edge", line_irq, 8'h30);
        chk("R7 irq edge", {7'd0, irq}, 8'h01);
        wr(8'h9C, 8'h00);
        chk("R7 disabled", line_irq, 8'h00);
        chk("R7 irq disabled", {7'd0, irq}, 8'h00);

        // R12 writes to read-only / unmapped
        wr(8'hA0, 8'hFF); wr(8'hA4, 8'hFF); wr(8'h50, 8'hFF);
        rd(8'hA4, rv); chk("R12 raw unchanged", rv, 8'hFA);
        rd(8'h9C, rv); chk("R12 enable unchanged", rv, 8'h00);
        rd(8'h50, rv); chk("R12 unmapped read", rv, 8'h00);

        // R11 leaving edge mode drops latches; level view with pins 0, pol 0x0F
        wr(8'h90, 8'h00); idle(1);
        rd(8'hA4, rv); chk("R11 level view", rv, 8'hF0);
        wr(8'h90, 8'hFF); idle(1);
        rd(8'hA4, rv); chk("R11 latches gone", rv, 8'h00);

        // R9 debounce on line 0, rising edge
        wr(8'h94, 8'hFF);
        wr(8'hA8, 8'h01);
        wr(8'h9C, 8'h01);
        wr(8'h98, 8'hFF);
        pin_in = 8'h01; idle(6);
        chk("R9 no tick no event", line_irq, 8'h00);
        pulse_tick(); pulse_tick(); pulse_tick();
        chk("R9 three ticks", line_irq, 8'h00);
        pulse_tick(); idle(2);
        chk("R9 fourth tick", line_irq, 8'h01);

        // R10 glitch shorter than filter window, falling edge selected
        wr(8'h94, 8'h00);
        wr(8'h98, 8'h01); idle(1);
        chk("R10 cleared", line_irq, 8'h00);
        pin_in = 8'h00; idle(4);
        pulse_tick(); pulse_tick();
        pin_in = 8'h01; idle(4);
        pulse_tick(); pulse_tick(); pulse_tick(); pulse_tick();
        idle(2);
        rd(8'hA4, rv); chk("R10 glitch ignored", rv & 8'h01, 8'h00);
        pin_in = 8'h00; idle(4);
        pulse_tick(); pulse_tick(); pulse_tick();
        chk("R10 count restarted", line_irq, 8'h00);
        pulse_tick(); idle(2);
        chk("R10 real fall", line_irq, 8'h01);

        summary();
        $finish;
    end
endmodule